// File: doc/BRIEF.md
# Exception Entry State Sequencer

This block performs the register update a CPU core makes when it takes an interrupt or a synchronous exception. When a strobe is accepted, the block does the following in one clock edge:

- It latches the event code into an interrupt-event or exception-event register.
- It saves the live status word, the return address and the stack pointer (general register 15) into shadow registers.
- It forms a new status word with the block, privileged-mode and register-bank bits forced high.
- It computes the handler address by adding an offset to the vector base.

Interrupts always use the fixed offset 0x600. Exceptions use an offset that the caller supplies. An exception requested while the block bit of the live status word is already set cannot be serviced. The block reports it on a fatal-error output and leaves every register unchanged. A one-cycle completion pulse lets the fetch stage redirect to the handler address.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is held, and after it is released, every registered output reads zero until the first accepted entry.
- R2: An accepted interrupt (intAccept high, excReq low) does four things: it loads intEvent with intCode, loads savedPc with curPc, sets nextPc to vecBase + 0x600 and leaves excEvent unchanged.
- R3: An accepted exception (excReq high, status bit 28 low) does four things: it loads excEvent with excCode, loads savedPc with excPc, sets nextPc to vecBase + excOffset and leaves intEvent unchanged.
- R4: Every accepted entry copies curStatus into savedStatus and curR15 into savedStack.
- R5: Every accepted entry sets newStatus to curStatus with bits 28 (block), 29 (register bank) and 30 (privileged mode) forced to 1, and all other bits copied unchanged.
- R6: When excReq and intAccept are high in the same cycle, only the exception is taken, as in R3.
- R7: excReq while curStatus bit 28 is 1 is fatal. fatalErr is high for exactly the following cycle, no register changes, and entryDone stays low. This holds even if intAccept is also high.
- R8: entryDone is high for the cycle after each accepted entry and low after any cycle without one. Back-to-back entries give consecutive pulses.
- R9: In a cycle with neither strobe, all shadow registers, newStatus and nextPc hold their values.
- R10: The handler address sum wraps modulo 2^32.
- R11: An interrupt accepted while status bit 28 is 1 is still taken; the block bit only gates exceptions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intAccept | input | 1 | Interrupt accepted this cycle |
| intCode | input | 12 | Event code of the winning interrupt |
| excReq | input | 1 | Exception raised this cycle |
| excCode | input | 12 | Exception event code |
| excPc | input | 32 | Faulting instruction address |
| excOffset | input | 32 | Handler offset for the exception |
| curPc | input | 32 | Next sequential PC |
| curStatus | input | 32 | Live status word |
| curR15 | input | 32 | Live stack pointer |
| vecBase | input | 32 | Vector base address |
| intEvent | output | 12 | Interrupt event register |
| excEvent | output | 12 | Exception event register |
| savedStatus | output | 32 | Saved status word |
| savedPc | output | 32 | Saved return address |
| savedStack | output | 32 | Saved stack pointer |
| newStatus | output | 32 | Status word for the handler |
| nextPc | output | 32 | Handler address |
| entryDone | output | 1 | One-cycle pulse after an accepted entry |
| fatalErr | output | 1 | One-cycle pulse after a blocked exception |

## Verification
Each result, whether a register update, the entryDone pulse or the fatalErr pulse, is due exactly one rising edge after the cycle in which the strobe was driven. None is due later. The driver sets inputs on the falling edge and pushes one expected item per cycle. The monitor pops that item one nanosecond after the next rising edge, so each comparison falls in the first cycle where the result is due. Because an expected item is also pushed for every idle and fatal cycle, holding behaviour and single-cycle pulse widths are compared cycle by cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // write shadow registers this edge
    logic useExc;    // select the exception sources
    logic fatal;     // blocked exception, write nothing
  } entryCtl_t;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BL_BIT = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intAccept,
  input  logic              excReq,
  input  logic [DATA_W-1:0] curStatus,
  output entryCtl_t         ctl,
  output logic              entryDone,
  output logic              fatalErr
);
  logic blocked;

  always_comb begin
    blocked     = curStatus[BL_BIT];
    ctl.useExc  = excReq;
    ctl.fatal   = excReq & blocked;
    ctl.capture = excReq ? ~blocked : intAccept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryDone <= 1'b0;
      fatalErr  <= 1'b0;
    end else begin
      entryDone <= ctl.capture;
      fatalErr  <= ctl.fatal;
    end
  end
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CODE_W      = 12,
  parameter int INTR_OFFSET = 'h600,
  parameter int BL_BIT      = 28,
  parameter int RB_BIT      = 29,
  parameter int MD_BIT      = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  entryCtl_t         ctl,
  input  logic [CODE_W-1:0] intCode,
  input  logic [CODE_W-1:0] excCode,
  input  logic [ADDR_W-1:0] excPc,
  input  logic [ADDR_W-1:0] excOffset,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [DATA_W-1:0] curStatus,
  input  logic [DATA_W-1:0] curR15,
  input  logic [ADDR_W-1:0] vecBase,
  output logic [CODE_W-1:0] intEvent,
  output logic [CODE_W-1:0] excEvent,
  output logic [DATA_W-1:0] savedStatus,
  output logic [ADDR_W-1:0] savedPc,
  output logic [DATA_W-1:0] savedStack,
  output logic [DATA_W-1:0] newStatus,
  output logic [ADDR_W-1:0] nextPc
);
  localparam logic [DATA_W-1:0] ENTRY_MASK =
      (DATA_W'(1) << BL_BIT) | (DATA_W'(1) << RB_BIT) | (DATA_W'(1) << MD_BIT);
  localparam logic [ADDR_W-1:0] INTR_OFS = ADDR_W'(INTR_OFFSET);

  logic [ADDR_W-1:0] selOffset;
  logic [ADDR_W-1:0] selRet;
  logic [ADDR_W-1:0] handlerPc;

  always_comb begin
    selOffset = ctl.useExc ? excOffset : INTR_OFS;
    selRet    = ctl.useExc ? excPc : curPc;
    handlerPc = vecBase + selOffset;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEvent    <= '0;
      excEvent    <= '0;
      savedStatus <= '0;
      savedPc     <= '0;
      savedStack  <= '0;
      newStatus   <= '0;
      nextPc      <= '0;
    end else if (ctl.capture) begin
      if (ctl.useExc) excEvent <= excCode;
      else            intEvent <= intCode;
      savedStatus <= curStatus;
      savedPc     <= selRet;
      savedStack  <= curR15;
      newStatus   <= curStatus | ENTRY_MASK;
      nextPc      <= handlerPc;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CODE_W      = 12,
  parameter int INTR_OFFSET = 'h600,
  parameter int BL_BIT      = 28,
  parameter int RB_BIT      = 29,
  parameter int MD_BIT      = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intAccept,
  input  logic [CODE_W-1:0] intCode,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic [ADDR_W-1:0] excPc,
  input  logic [ADDR_W-1:0] excOffset,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [DATA_W-1:0] curStatus,
  input  logic [DATA_W-1:0] curR15,
  input  logic [ADDR_W-1:0] vecBase,
  output logic [CODE_W-1:0] intEvent,
  output logic [CODE_W-1:0] excEvent,
  output logic [DATA_W-1:0] savedStatus,
  output logic [ADDR_W-1:0] savedPc,
  output logic [DATA_W-1:0] savedStack,
  output logic [DATA_W-1:0] newStatus,
  output logic [ADDR_W-1:0] nextPc,
  output logic              entryDone,
  output logic              fatalErr
);
  entryCtl_t ctl;

  exc_entry_ctrl #(.DATA_W(DATA_W), .BL_BIT(BL_BIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .intAccept(intAccept), .excReq(excReq),
    .curStatus(curStatus), .ctl(ctl), .entryDone(entryDone), .fatalErr(fatalErr)
  );

  exc_entry_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .INTR_OFFSET(INTR_OFFSET),
    .BL_BIT(BL_BIT), .RB_BIT(RB_BIT), .MD_BIT(MD_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .intCode(intCode), .excCode(excCode), .excPc(excPc), .excOffset(excOffset),
    .curPc(curPc), .curStatus(curStatus), .curR15(curR15), .vecBase(vecBase),
    .intEvent(intEvent), .excEvent(excEvent), .savedStatus(savedStatus),
    .savedPc(savedPc), .savedStack(savedStack), .newStatus(newStatus), .nextPc(nextPc)
  );
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CODE_W      = 12,
  parameter int INTR_OFFSET = 'h600,
  parameter int BL_BIT      = 28,
  parameter int RB_BIT      = 29,
  parameter int MD_BIT      = 30
) (
  input logic              clk,
  input logic              rstN,
  input logic              intAccept,
  input logic              excReq,
  input logic [DATA_W-1:0] curStatus,
  input logic [DATA_W-1:0] curR15,
  input logic [ADDR_W-1:0] vecBase,
  input logic [CODE_W-1:0] intEvent,
  input logic [DATA_W-1:0] savedStatus,
  input logic [DATA_W-1:0] savedStack,
  input logic [DATA_W-1:0] newStatus,
  input logic [ADDR_W-1:0] nextPc,
  input logic              entryDone,
  input logic              fatalErr
);
  // R8
  accept_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((excReq && !curStatus[BL_BIT]) || (!excReq && intAccept)) |=> entryDone);
  // R8
  idle_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!excReq && !intAccept) |=> (!entryDone && !fatalErr));
  // R7
  blocked_fatal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && curStatus[BL_BIT]) |=> (fatalErr && !entryDone && $stable(nextPc) && $stable(savedStatus)));
  // R5
  entry_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |-> (newStatus[BL_BIT] && newStatus[RB_BIT] && newStatus[MD_BIT]));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!excReq && !intAccept) |=> ($stable(nextPc) && $stable(savedStatus) && $stable(savedStack) && $stable(newStatus)));
  // R3
  exc_keeps_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> $stable(intEvent));
  // R2
  int_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAccept && !excReq) |=> (nextPc == ADDR_W'($past(vecBase) + ADDR_W'(INTR_OFFSET))));
  // R4
  save_stack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAccept && !excReq) |=> (savedStack == $past(curR15) && savedStatus == $past(curStatus)));
  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(entryDone && fatalErr));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .INTR_OFFSET(INTR_OFFSET),
  .BL_BIT(BL_BIT), .RB_BIT(RB_BIT), .MD_BIT(MD_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .intAccept(intAccept), .excReq(excReq),
  .curStatus(curStatus), .curR15(curR15), .vecBase(vecBase),
  .intEvent(intEvent), .savedStatus(savedStatus), .savedStack(savedStack),
  .newStatus(newStatus), .nextPc(nextPc), .entryDone(entryDone), .fatalErr(fatalErr)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intAccept = 1'b0, excReq = 1'b0;
  logic [11:0] intCode = '0, excCode = '0;
  logic [31:0] excPc = '0, excOffset = '0, curPc = '0, curStatus = '0, curR15 = '0, vecBase = '0;
  logic [11:0] intEvent, excEvent;
  logic [31:0] savedStatus, savedPc, savedStack, newStatus, nextPc;
  logic entryDone, fatalErr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rstN(rstN), .intAccept(intAccept), .intCode(intCode),
    .excReq(excReq), .excCode(excCode), .excPc(excPc), .excOffset(excOffset),
    .curPc(curPc), .curStatus(curStatus), .curR15(curR15), .vecBase(vecBase),
    .intEvent(intEvent), .excEvent(excEvent), .savedStatus(savedStatus),
    .savedPc(savedPc), .savedStack(savedStack), .newStatus(newStatus),
    .nextPc(nextPc), .entryDone(entryDone), .fatalErr(fatalErr)
  );

  typedef struct {
    string tag;
    logic [31:0] ie, ee, ss, sp, sk, ns, np;
    logic dn, fe;
  } expItem_t;

  expItem_t q[$];
  expItem_t m;  // model state

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic ia, logic [11:0] ic, logic er, logic [11:0] ec,
                      logic [31:0] epc, logic [31:0] eof, logic [31:0] pc,
                      logic [31:0] st, logic [31:0] r15, logic [31:0] vb);
    logic blk, cap;
    expItem_t it;
    @(negedge clk);
    intAccept = ia; intCode = ic; excReq = er; excCode = ec; excPc = epc;
    excOffset = eof; curPc = pc; curStatus = st; curR15 = r15; vecBase = vb;
    blk = st[28];
    cap = er ? !blk : ia;
    if (cap) begin
      m.ss = st; m.sk = r15; m.ns = st | 32'h7000_0000;
      if (er) begin m.ee = {20'h0, ec}; m.sp = epc; m.np = vb + eof; end
      else    begin m.ie = {20'h0, ic}; m.sp = pc;  m.np = vb + 32'h600; end
    end
    m.dn = cap;
    m.fe = er && blk;
    it = m;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 12'h0, 0, 12'h0, 0, 0, 0, 0, 0, 0);
  endtask

  // monitor: results due one rising edge after the drive
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk(it.tag, "intEvent",    {20'h0, intEvent}, it.ie);
        chk(it.tag, "excEvent",    {20'h0, excEvent}, it.ee);
        chk(it.tag, "savedStatus", savedStatus, it.ss);
        chk(it.tag, "savedPc",     savedPc, it.sp);
        chk(it.tag, "savedStack",  savedStack, it.sk);
        chk(it.tag, "newStatus",   newStatus, it.ns);
        chk(it.tag, "nextPc",      nextPc, it.np);
        chk(it.tag, "entryDone",   {31'h0, entryDone}, {31'h0, it.dn});
        chk(it.tag, "fatalErr",    {31'h0, fatalErr}, {31'h0, it.fe});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m = '{tag: "", ie: 0, ee: 0, ss: 0, sp: 0, sk: 0, ns: 0, np: 0, dn: 0, fe: 0};
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs zero under reset
    chk("R1", "nextPc", nextPc, 0);
    chk("R1", "newStatus", newStatus, 0);
    chk("R1", "entryDone", {31'h0, entryDone}, 0);
    @(negedge clk);
    rstN = 1'b1;
    idle("R1");
    // R2 R4 R5: plain interrupt
    step("R2", 1, 12'h320, 0, 12'h0, 32'h0, 32'h0, 32'h8C00_1000, 32'h0000_00F0, 32'h8CFF_FF00, 32'h8C00_0000);
    idle("R9");
    // R3 R4 R5: plain exception
    step("R3", 0, 12'h0, 1, 12'h1E0, 32'h8C00_2222, 32'h100, 32'h8C00_2224, 32'h0000_0301, 32'h1234_5678, 32'h8C00_0000);
    // R6: both together, exception wins
    step("R6", 1, 12'h3A0, 1, 12'h0A0, 32'h0000_4000, 32'h400, 32'h0000_4002, 32'h8000_0000, 32'h5555_AAAA, 32'h0001_0000);
    // R7: blocked exception is fatal, nothing updated
    step("R7", 0, 12'h0, 1, 12'h0C0, 32'hDEAD_0000, 32'h100, 32'h0, 32'h1000_0000, 32'h9999_9999, 32'h0F00_0000);
    // R7: blocked exception with interrupt also raised
    step("R7", 1, 12'h600, 1, 12'h0C0, 32'hDEAD_0004, 32'h100, 32'h77, 32'h1000_00FF, 32'h8888_8888, 32'h0F00_0000);
    idle("R8");
    // R11: interrupt taken while block bit set
    step("R11", 1, 12'h640, 0, 12'h0, 32'h0, 32'h0, 32'hA000_0000, 32'h1000_0000, 32'h0000_0010, 32'h0000_2000);
    // R10: handler address wraps
    step("R10", 1, 12'h400, 0, 12'h0, 32'h0, 32'h0, 32'h0000_0100, 32'h0, 32'h0, 32'hFFFF_FF00);
    step("R10", 0, 12'h0, 1, 12'h040, 32'h0000_0200, 32'h0000_0400, 32'h0, 32'h0, 32'h0, 32'hFFFF_FE00);
    // R8: back-to-back entries give consecutive pulses
    step("R8", 1, 12'h420, 0, 12'h0, 32'h0, 32'h0, 32'h0000_3000, 32'h0, 32'h1, 32'h0);
    step("R8", 0, 12'h0, 1, 12'h160, 32'h0000_3004, 32'h100, 32'h0, 32'h0, 32'h2, 32'h0);
    idle("R9");
    // mixed patterns covering R2..R9
    for (int i = 0; i < 40; i++) begin
      step("R4", 1'($urandom), 12'($urandom), 1'($urandom), 12'($urandom), $urandom,
           $urandom, $urandom, $urandom, $urandom, $urandom);
    end
    idle("R9");
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule